// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns parallel characters into a framed asynchronous bit stream on one output line. Software-side logic presents a byte with a one-cycle write strobe. The byte goes into a single holding slot, and from there into the shifter whenever the shifter is free. The shifter sends a low start bit, then the chosen number of data bits starting with the least significant one, then an optional parity bit, then one, one and a half or two high stop bits.

Bit timing comes from an external transmit clock. That clock is sampled by the system clock, and its falling edges are counted. A bit lasts 1, 16, 32 or 64 of those edges, chosen by a mode code. A break level input holds the line low for as long as it is asserted and throws away any character that is being shifted. When the break ends, the line is high for a full bit time before any new start bit.

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever no character is pending or shifting, `txd` is high and `tbe` is high.
- R2: While `brk` is high, `txd` is low from the system clock edge that samples `brk` high. A character that is shifting when break arrives is discarded and is not resumed.
- R3: A frame is a low start bit, then the data bits with bit 0 first, then the optional parity bit, then high stop level.
- R4: `char_len` selects the data bit count: 00 gives 5, 10 gives 6, 01 gives 7 and 11 gives 8. Data bits at or above that count are not sent and do not affect parity.
- R5: With `par_en` high, a parity bit follows the data. With `par_odd` low it makes the count of ones in data plus parity even. With `par_odd` high it makes that count odd. With `par_en` low, no parity bit is sent.
- R6: `stop_sel` 01 gives one stop bit, 10 gives one and a half and 11 gives two. Code 00 is treated as one stop bit.
- R7: In x1 mode a one-and-a-half stop setting lasts two bit times. In divided modes it lasts the divisor plus half the divisor in transmit clock falling edges.
- R8: `clk_mode` 00, 01, 10 and 11 make each bit last 1, 16, 32 or 64 falling edges of `tx_clk`. `txd` changes only on the system clock edge that first samples `tx_clk` low after sampling it high, or because of break.
- R9: A write strobe while `tbe` is high stores the byte and drops `tbe` on the next edge. `tbe` rises only when the stored byte moves into the shifter. A write strobe while `tbe` is low is ignored.
- R10: If a byte is waiting when a frame's stop time ends, its start bit begins on that same edge, with no idle gap.
- R11: After `brk` falls, `txd` is high for one full bit time (the current divisor in falling edges) before any start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk | input | 1 | External transmit bit clock, sampled by `clk` |
| char_len | input | 2 | Data bit count code |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Parity sense, 1 = odd |
| stop_sel | input | 2 | Stop length code |
| clk_mode | input | 2 | Transmit clock divisor code |
| brk | input | 1 | Break level, holds the line low |
| wr_stb | input | 1 | One-cycle write strobe for `wr_data` |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| tbe | output | 1 | Holding slot empty flag |

## Verification
The bench instantiates the block with its default package values: an 8-bit data path and a 7-bit edge counter. That counter is wide enough for two 64-edge bit times, so the longest stop setting in the slowest mode can be reached. All four divisor modes, every length code, both parity senses and every stop code are selected through the control inputs at run time, within one build. Because the transmit clock falls every four system cycles, even x64 frames finish quickly. Break is applied both in the middle of a character and while a byte waits in the holding slot.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int DATA_W  = 8;
  localparam int MAX_DIV = 64;
  localparam int CNT_W   = $clog2(2 * MAX_DIV);
  localparam int LEN_W   = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK,
    ST_GAP
  } tx_state_e;

  // data bit count for a length code
  function automatic logic [LEN_W-1:0] bits_of(input logic [1:0] code);
    case (code)
      2'b00:   bits_of = LEN_W'(5);
      2'b10:   bits_of = LEN_W'(6);
      2'b01:   bits_of = LEN_W'(7);
      default: bits_of = LEN_W'(8);
    endcase
  endfunction

  // divisor minus one for a clock mode code
  function automatic logic [CNT_W-1:0] div_m1(input logic [1:0] code);
    case (code)
      2'b00:   div_m1 = CNT_W'(0);
      2'b01:   div_m1 = CNT_W'(15);
      2'b10:   div_m1 = CNT_W'(31);
      default: div_m1 = CNT_W'(63);
    endcase
  endfunction

endpackage

// File: rtl/async_tx_tick.sv
module async_tx_tick
  import async_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_clk,
  input  logic [1:0]       clk_mode,
  input  logic [1:0]       stop_sel,
  output logic             fall,
  output logic [CNT_W-1:0] bit_last,
  output logic [CNT_W-1:0] stop_last
);

  logic             txc_q;
  logic [CNT_W-1:0] half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txc_q <= 1'b0;
    else        txc_q <= tx_clk;
  end

  assign fall = txc_q & ~tx_clk;

  always_comb begin
    bit_last = div_m1(clk_mode);
    half     = (bit_last + CNT_W'(1)) >> 1;
    case (stop_sel)
      2'b10:   stop_last = (clk_mode == 2'b00) ? CNT_W'(1) : bit_last + half;
      2'b11:   stop_last = {bit_last[CNT_W-2:0], 1'b1};
      default: stop_last = bit_last;
    endcase
  end

endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic full_n;
  logic accept;

  always_comb begin
    accept = wr_stb & ~full;
    full_n = accept | (full & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data <= '0;
    else if (accept) data <= wr_data;
  end

endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              brk,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [CNT_W-1:0]  bit_last,
  input  logic [CNT_W-1:0]  stop_last,
  output logic              take,
  output logic              txd
);

  tx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [LEN_W-1:0]  left_q, left_n;
  logic              par_q, par_n;
  logic              pon_q, pon_n;
  logic [CNT_W-1:0]  bl_q, bl_n;
  logic [CNT_W-1:0]  sl_q, sl_n;
  logic              txd_n;

  logic [LEN_W-1:0]  len_w;
  logic [DATA_W-1:0] mask_w;
  logic [DATA_W-1:0] masked_w;
  logic              elem_end;

  always_comb begin
    len_w    = bits_of(char_len);
    mask_w   = {DATA_W{1'b1}} >> (DATA_W - int'(len_w));
    masked_w = hold_data & mask_w;
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    left_n = left_q;
    par_n  = par_q;
    pon_n  = pon_q;
    bl_n   = bl_q;
    sl_n   = sl_q;
    txd_n  = txd;
    take   = 1'b0;
    elem_end = 1'b0;

    if (brk) begin
      st_n  = ST_BRK;
      txd_n = 1'b0;
    end else if (st_q == ST_BRK) begin
      st_n  = ST_GAP;
      cnt_n = bit_last;
      bl_n  = bit_last;
      txd_n = 1'b1;
    end else if (fall) begin
      if (st_q != ST_IDLE && cnt_q != '0) begin
        cnt_n = cnt_q - CNT_W'(1);
      end else begin
        case (st_q)
          ST_START: begin
            st_n  = ST_DATA;
            cnt_n = bl_q;
            txd_n = sh_q[0];
          end
          ST_DATA: begin
            cnt_n = bl_q;
            if (left_q != '0) begin
              left_n = left_q - LEN_W'(1);
              sh_n   = sh_q >> 1;
              txd_n  = sh_q[1];
            end else if (pon_q) begin
              st_n  = ST_PAR;
              txd_n = par_q;
            end else begin
              st_n  = ST_STOP;
              cnt_n = sl_q;
              txd_n = 1'b1;
            end
          end
          ST_PAR: begin
            st_n  = ST_STOP;
            cnt_n = sl_q;
            txd_n = 1'b1;
          end
          default: elem_end = 1'b1;
        endcase
      end
    end

    if (elem_end) begin
      if (hold_full) begin
        take   = 1'b1;
        st_n   = ST_START;
        cnt_n  = bit_last;
        bl_n   = bit_last;
        sl_n   = stop_last;
        sh_n   = masked_w;
        left_n = len_w - LEN_W'(1);
        par_n  = (^masked_w) ^ par_odd;
        pon_n  = par_en;
        txd_n  = 1'b0;
      end else begin
        st_n  = ST_IDLE;
        txd_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      left_q <= '0;
      par_q  <= 1'b0;
      pon_q  <= 1'b0;
      bl_q   <= '0;
      sl_q   <= '0;
      txd    <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      par_q  <= par_n;
      pon_q  <= pon_n;
      bl_q   <= bl_n;
      sl_q   <= sl_n;
      txd    <= txd_n;
    end
  end

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_clk,
  input  logic [1:0]  char_len,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic [1:0]  stop_sel,
  input  logic [1:0]  clk_mode,
  input  logic        brk,
  input  logic        wr_stb,
  input  logic [7:0]  wr_data,
  output logic        txd,
  output logic        tbe
);

  logic              fall;
  logic [CNT_W-1:0]  bit_last;
  logic [CNT_W-1:0]  stop_last;
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  async_tx_tick u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_clk    (tx_clk),
    .clk_mode  (clk_mode),
    .stop_sel  (stop_sel),
    .fall      (fall),
    .bit_last  (bit_last),
    .stop_last (stop_last)
  );

  async_tx_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  async_tx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall      (fall),
    .brk       (brk),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .char_len  (char_len),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .bit_last  (bit_last),
    .stop_last (stop_last),
    .take      (take),
    .txd       (txd)
  );

  assign tbe = ~hold_full;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_clk,
  input logic brk,
  input logic wr_stb,
  input logic txd,
  input logic tbe
);

  logic txc_seen;
  logic brk_seen;
  logic fall_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_seen <= 1'b0;
      brk_seen <= 1'b0;
    end else begin
      txc_seen <= tx_clk;
      brk_seen <= brk;
    end
  end

  assign fall_c = txc_seen & ~tx_clk;

  // R2: break forces the line low on the following sample
  p_break_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);

  // R11: releasing break drives the line high
  p_release_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_seen && !brk) |=> txd);

  // R8: without a transmit clock fall or a break event, the line holds
  p_line_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_c && !brk && !brk_seen) |=> $stable(txd));

  // R9: an accepted write fills the slot
  p_write_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tbe && wr_stb) |=> !tbe);

  // R9: the slot only empties on a transmit clock fall
  p_slot_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbe && !fall_c) |=> !tbe);

endmodule

bind async_tx async_tx_chk u_chk (.*);

// File: tb/async_tx_test.sv
module async_tx_test;

  logic       clk;
  logic       rst_n;
  logic       tx_clk;
  logic [1:0] char_len;
  logic       par_en;
  logic       par_odd;
  logic [1:0] stop_sel;
  logic [1:0] clk_mode;
  logic       brk;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       txd;
  logic       tbe;

  int    nvec = 0;
  int    nerr = 0;
  string cur_req = "R1";

  // reference model state
  int   m_lv[$];
  int   m_dr[$];
  int   m_rem;
  bit   m_txd;
  bit   m_full;
  bit   m_brk;
  bit   m_ptx;
  logic [7:0] m_data;

  async_tx uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_clk   (tx_clk),
    .char_len (char_len),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .stop_sel (stop_sel),
    .clk_mode (clk_mode),
    .brk      (brk),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .txd      (txd),
    .tbe      (tbe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    tx_clk = 1'b1;
    forever begin
      repeat (2) @(negedge clk);
      tx_clk = ~tx_clk;
    end
  end

  function automatic int divisor();
    case (clk_mode)
      2'b00:   return 1;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int nbits();
    case (char_len)
      2'b00:   return 5;
      2'b10:   return 6;
      2'b01:   return 7;
      default: return 8;
    endcase
  endfunction

  function automatic int stop_len();
    int d = divisor();
    case (stop_sel)
      2'b10:   return (d == 1) ? 2 : d + d / 2;
      2'b11:   return 2 * d;
      default: return d;
    endcase
  endfunction

  task automatic build_frame(input logic [7:0] d);
    int ones = 0;
    int dv = divisor();
    m_lv.push_back(0); m_dr.push_back(dv);
    for (int i = 0; i < nbits(); i++) begin
      m_lv.push_back(int'(d[i])); m_dr.push_back(dv);
      ones += int'(d[i]);
    end
    if (par_en) begin
      m_lv.push_back(((ones % 2) == 1) ^ par_odd ? 1 : 0);
      m_dr.push_back(dv);
    end
    m_lv.push_back(1); m_dr.push_back(stop_len());
    m_rem = m_dr[0];
    m_txd = (m_lv[0] != 0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lv.delete(); m_dr.delete();
      m_txd = 1; m_full = 0; m_brk = 0; m_ptx = 0; m_rem = 0; m_data = '0;
    end else begin
      bit fl;
      bit old_full;
      fl = m_ptx && !tx_clk;
      m_ptx = tx_clk;
      old_full = m_full;
      if (brk) begin
        m_lv.delete(); m_dr.delete();
        m_brk = 1; m_txd = 0;
      end else if (m_brk) begin
        m_brk = 0;
        m_lv.push_back(1); m_dr.push_back(divisor());
        m_rem = divisor(); m_txd = 1;
      end else if (fl) begin
        if (m_lv.size() != 0) begin
          m_rem--;
          if (m_rem == 0) begin
            void'(m_lv.pop_front()); void'(m_dr.pop_front());
            if (m_lv.size() != 0) begin
              m_rem = m_dr[0];
              m_txd = (m_lv[0] != 0);
            end
          end
        end
        if (m_lv.size() == 0) begin
          if (old_full) begin
            build_frame(m_data);
            m_full = 0;
          end else begin
            m_txd = 1;
          end
        end
      end
      if (wr_stb && !old_full) begin
        m_full = 1;
        m_data = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      nvec++;
      if (txd !== m_txd || tbe !== !m_full) begin
        nerr++;
        $display("FAIL %s t=%0t txd=%b tbe=%b expected txd=%b tbe=%b",
                 cur_req, $time, txd, tbe, m_txd, !m_full);
      end
    end
  end

  task automatic send(input logic [7:0] d);
    while (!tbe) @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic wait_done();
    while (m_lv.size() != 0 || m_full) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] cl, input logic pe, input logic po,
                       input logic [1:0] ss, input logic [1:0] cm);
    char_len = cl; par_en = pe; par_odd = po; stop_sel = ss; clk_mode = cm;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL %s watchdog expired actual=running expected=finished", cur_req);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; brk = 1'b0; wr_stb = 1'b0; wr_data = '0;
    setup(2'b11, 1'b0, 1'b0, 2'b01, 2'b00);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state seen at the ports
    cur_req = "R1";
    nvec++;
    if (txd !== 1'b1 || tbe !== 1'b1) begin
      nerr++;
      $display("FAIL R1 reset txd=%b tbe=%b expected txd=1 tbe=1", txd, tbe);
    end
    repeat (20) @(negedge clk);

    // R3 R8: x1, 8 bits, no parity, one stop
    cur_req = "R3";
    send(8'hA5);
    wait_done();

    // R9 R10: back to back with a write ignored while the slot is full
    cur_req = "R10";
    send(8'h3C);
    send(8'hC3);
    cur_req = "R9";
    wr_stb = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr_stb = 1'b0;
    wait_done();

    // R4 R5: 5 bits with upper bits set, even parity
    cur_req = "R4";
    setup(2'b00, 1'b1, 1'b0, 2'b01, 2'b00);
    send(8'hE6);
    send(8'h1F);
    wait_done();

    // R5: 7 bits, odd parity; R7: 1.5 stop rounded up in x1
    cur_req = "R5";
    setup(2'b01, 1'b1, 1'b1, 2'b10, 2'b00);
    send(8'hD3);
    cur_req = "R7";
    send(8'h80);
    wait_done();

    // R6 R7 R8: x16, 6 bits, 1.5 stop
    cur_req = "R7";
    setup(2'b10, 1'b0, 1'b0, 2'b10, 2'b01);
    send(8'h2B);
    send(8'h15);
    wait_done();

    // R6 R8: x32, 2 stops, even parity
    cur_req = "R6";
    setup(2'b11, 1'b1, 1'b0, 2'b11, 2'b10);
    send(8'h71);
    wait_done();

    // R8: x64, 5 bits, stop code 00 acts as one stop
    cur_req = "R8";
    setup(2'b00, 1'b0, 1'b0, 2'b00, 2'b11);
    send(8'h0A);
    send(8'h15);
    wait_done();

    // R2 R11: break in the middle of a character, byte waiting meanwhile
    cur_req = "R2";
    setup(2'b11, 1'b0, 1'b0, 2'b01, 2'b01);
    send(8'h00);
    repeat (150) @(negedge clk);
    brk = 1'b1;
    repeat (10) @(negedge clk);
    send(8'h5A);
    repeat (60) @(negedge clk);
    cur_req = "R11";
    brk = 1'b0;
    wait_done();

    // R2 R11: break from idle in x1 mode, then a character
    cur_req = "R2";
    setup(2'b11, 1'b0, 1'b0, 2'b01, 2'b00);
    brk = 1'b1;
    repeat (9) @(negedge clk);
    cur_req = "R11";
    brk = 1'b0;
    send(8'h96);
    wait_done();

    // R1: back to idle
    cur_req = "R1";
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule